// File: doc/BRIEF.md
# Integer Multiply Unit

This block computes the 32-bit result of an integer multiply for a RISC-V style execution stage. Each request carries two operands and a two-bit operation code. The operation code picks the low word of the product, or the high word with both operands signed, with the first operand signed and the second unsigned, or with both unsigned. Each operand is sign-extended or zero-extended to double width, and the requested word is taken from the one double-width product.

A one-cycle `start_i` pulse, given while the unit is idle, captures the operands and the operation code. `busy_o` then stays high while the unit forms the product with one shift-and-add step per cycle. The step count is fixed and does not depend on the data. A one-cycle `done_o` pulse marks completion. `result_o` then holds the answer until the next accepted start. A start given while the unit is busy has no effect.

A parameter selects a single-step variant, which forms the whole product in one cycle under the same handshake.

Top module: `mul_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy_o` and `done_o` go low after that edge. After reset `result_o` reads zero.
- R2: A start pulse taken while `busy_o` is low captures `opa_i`, `opb_i` and `op_i`, and `busy_o` is high in the next cycle.
- R3: In the default iterative form `busy_o` stays high for exactly 33 cycles after the accepting edge. `done_o` is then high for one cycle, in the same cycle that `busy_o` falls, and is never high together with `busy_o`.
- R4: Code 2'b00 returns bits 31:0 of the product, and this word does not depend on signedness.
- R5: Code 2'b01 returns bits 63:32 of the product with both operands sign-extended.
- R6: Code 2'b10 returns bits 63:32 of the product with the first operand sign-extended and the second zero-extended.
- R7: Code 2'b11 returns bits 63:32 of the product with both operands zero-extended.
- R8: Once `done_o` has pulsed, `result_o` keeps its value while no start is accepted, whatever the operand and operation inputs do.
- R9: A start pulse while `busy_o` is high is ignored. The running operation finishes on its original schedule with its original operands, and no second operation follows it.
- R10: Edge operands give correct results under all four codes: 0x80000000 times 0xFFFFFFFF, zero times zero, a zero second operand with either sign of the first, and the largest-magnitude values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| op_i | input | 2 | Operation code: 00 low, 01 high s*s, 10 high s*u, 11 high u*u |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Selected word of the product, held after completion |

## Verification
The assertions assume that reset is held low for at least one rising edge before it is released, and that `start_i` and the operand inputs are stable around each rising edge. The stimulus changes every input at the falling edge and holds reset low for several cycles. It also deliberately drives `start_i` high during a busy period, because the block must tolerate that case. Results are compared with a double-width arithmetic model in the bench, both for the 32-bit unit and for a 4-bit copy that is swept over every operand pair and every code.

// File: rtl/mul_pkg.sv
// Shared types for the multiply unit.
// Holds the operation codes and the signedness of each operand per code.
package mul_pkg;

    typedef enum logic [1:0] {
        MOP_LO    = 2'b00,
        MOP_HI_SS = 2'b01,
        MOP_HI_SU = 2'b10,
        MOP_HI_UU = 2'b11
    } mul_op_e;

    // Returns whether the first operand is sign-extended for this code.
    function automatic logic op_a_signed(mul_op_e op);
        return op != MOP_HI_UU;
    endfunction

    // Returns whether the second operand is sign-extended for this code.
    function automatic logic op_b_signed(mul_op_e op);
        return (op == MOP_LO) || (op == MOP_HI_SS);
    endfunction

endpackage

// File: rtl/mul_opext.sv
// Operand extender.
// Widens the first operand to 2*XLEN bits and the second to XLEN+1 bits,
// using sign or zero fill as the operation code requires.
// Assumes: combinational only; its outputs are captured by the datapath at load.
module mul_opext
    import mul_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  mul_op_e             op,
    input  logic [XLEN-1:0]     a,
    input  logic [XLEN-1:0]     b,
    output logic [2*XLEN-1:0]   a_ext,
    output logic [XLEN:0]       b_ext
);

    logic a_fill;
    logic b_fill;

    // Pick the fill bit for each operand.
    always_comb begin
        a_fill = op_a_signed(op) & a[XLEN-1];
        b_fill = op_b_signed(op) & b[XLEN-1];
    end

    // Build the widened operands.
    always_comb begin
        a_ext = {{XLEN{a_fill}}, a};
        b_ext = {b_fill, b};
    end

endmodule

// File: rtl/mul_seq_ctrl.sv
// Sequencer for the multiply unit.
// Accepts a start only while idle, then runs STEPS step cycles,
// and ends with a one-cycle done pulse as busy falls.
// Assumes: start is synchronous; STEPS >= 1.
module mul_seq_ctrl #(
    parameter int STEPS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step_en,
    output logic last_step
);

    localparam int CW = $clog2(STEPS + 1);

    logic [CW-1:0] cnt;

    // Decode the handshake strobes from the state.
    always_comb begin
        load      = start & ~busy;
        step_en   = busy;
        last_step = busy && (cnt == CW'(STEPS - 1));
    end

    // Track busy, done and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (last_step) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mul_datapath.sv
// Product datapath.
// ITERATIVE=1: one shift-and-add step per cycle over the XLEN+1 bit
// multiplier. The last step subtracts, because the top multiplier bit has
// negative weight in two's complement.
// ITERATIVE=0: the whole product is formed in the single step.
// Assumes: load and step_en are never high in the same cycle.
module mul_datapath #(
    parameter int XLEN      = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step_en,
    input  logic                last_step,
    input  logic [2*XLEN-1:0]   a_ext,
    input  logic [XLEN:0]       b_ext,
    output logic [2*XLEN-1:0]   prod
);

    localparam int PW = 2 * XLEN;

    generate
        if (ITERATIVE) begin : g_iter
            logic [PW-1:0] acc;
            logic [PW-1:0] mcand;
            logic [XLEN:0] mplier;

            // Shift-and-add: add or subtract the shifted multiplicand per bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc    <= '0;
                    mcand  <= '0;
                    mplier <= '0;
                end else if (load) begin
                    acc    <= '0;
                    mcand  <= a_ext;
                    mplier <= b_ext;
                end else if (step_en) begin
                    if (mplier[0]) begin
                        acc <= last_step ? (acc - mcand) : (acc + mcand);
                    end
                    mcand  <= mcand << 1;
                    mplier <= mplier >> 1;
                end
            end

            assign prod = acc;
        end else begin : g_flat
            logic [PW-1:0] acc;
            logic [PW-1:0] a_q;
            logic [XLEN:0] b_q;
            logic [PW-1:0] b_wide;

            // Widen the stored multiplier to the product width.
            always_comb begin
                b_wide = {{(XLEN-1){b_q[XLEN]}}, b_q};
            end

            // Capture the operands, then form the whole product in one step.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc <= '0;
                    a_q <= '0;
                    b_q <= '0;
                end else if (load) begin
                    acc <= '0;
                    a_q <= a_ext;
                    b_q <= b_ext;
                end else if (step_en && last_step) begin
                    acc <= a_q * b_wide;
                end
            end

            assign prod = acc;
        end
    endgenerate

endmodule

// File: rtl/mul_unit.sv
// Top of the integer multiply unit.
// Captures the operands and the operation code on an accepted start, runs
// the datapath, and presents the low or high word of the product.
// Assumes: synchronous active-low reset; start ignored while busy.
module mul_unit
    import mul_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);

    localparam int STEPS = ITERATIVE ? (XLEN + 1) : 1;

    mul_op_e            op_in;
    mul_op_e            op_q;
    logic               load;
    logic               step_en;
    logic               last_step;
    logic [2*XLEN-1:0]  a_ext;
    logic [XLEN:0]      b_ext;
    logic [2*XLEN-1:0]  prod;

    assign op_in = mul_op_e'(op_i);

    mul_opext #(.XLEN(XLEN)) u_ext (
        .op    (op_in),
        .a     (opa_i),
        .b     (opb_i),
        .a_ext (a_ext),
        .b_ext (b_ext)
    );

    mul_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .busy      (busy_o),
        .done      (done_o),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step)
    );

    mul_datapath #(.XLEN(XLEN), .ITERATIVE(ITERATIVE)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step),
        .a_ext     (a_ext),
        .b_ext     (b_ext),
        .prod      (prod)
    );

    // Keep the operation code of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= MOP_LO;
        end else if (load) begin
            op_q <= op_in;
        end
    end

    // Select the low or high word of the product.
    always_comb begin
        result_o = (op_q == MOP_LO) ? prod[XLEN-1:0] : prod[2*XLEN-1:XLEN];
    end

endmodule

// File: rtl/mul_unit_chk.sv
// Protocol checker for mul_unit, attached with bind.
// Assumes: reset is held low for at least one rising edge at the start.
module mul_unit_chk #(
    parameter int XLEN      = 32,
    parameter bit ITERATIVE = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);

    localparam int STEPS = ITERATIVE ? (XLEN + 1) : 1;
    localparam int LW    = $clog2(STEPS + 1) + 1;

    logic [LW-1:0] lat_cnt;

    // Count the busy cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R2
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(lat_cnt) == STEPS));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

endmodule

bind mul_unit mul_unit_chk #(.XLEN(XLEN), .ITERATIVE(ITERATIVE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .busy   (busy_o),
    .done   (done_o),
    .result (result_o)
);

// File: tb/sim_mul_unit.sv
// Bench for mul_unit: a 32-bit unit with corner and random operands, and a
// 4-bit unit swept over every operand pair and every operation code.
module sim_mul_unit;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // 32-bit instance
    logic        st32 = 1'b0;
    logic [1:0]  op32 = 2'd0;
    logic [31:0] a32 = '0, b32 = '0;
    logic        busy32, dn32;
    logic [31:0] res32;

    mul_unit #(.XLEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(st32), .op_i(op32),
        .opa_i(a32), .opb_i(b32), .busy_o(busy32), .done_o(dn32), .result_o(res32)
    );

    // 4-bit instance for the exhaustive sweep
    logic       st4 = 1'b0;
    logic [1:0] op4 = 2'd0;
    logic [3:0] a4 = '0, b4 = '0;
    logic       busy4, dn4;
    logic [3:0] res4;

    mul_unit #(.XLEN(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(st4), .op_i(op4),
        .opa_i(a4), .opb_i(b4), .busy_o(busy4), .done_o(dn4), .result_o(res4)
    );

    int vecs = 0;
    int errs = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference model: widen each operand, multiply, select a word.
    function automatic logic [31:0] ref32(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [63:0] wa, wb, p;
        wa = (op != 2'd3 && a[31]) ? {32'hFFFF_FFFF, a} : {32'h0, a};
        wb = ((op == 2'd0 || op == 2'd1) && b[31]) ? {32'hFFFF_FFFF, b} : {32'h0, b};
        p = wa * wb;
        return (op == 2'd0) ? p[31:0] : p[63:32];
    endfunction

    function automatic logic [3:0] ref4(input logic [1:0] op, input logic [3:0] a,
                                        input logic [3:0] b);
        logic [7:0] wa, wb, p;
        wa = (op != 2'd3 && a[3]) ? {4'hF, a} : {4'h0, a};
        wb = ((op == 2'd0 || op == 2'd1) && b[3]) ? {4'hF, b} : {4'h0, b};
        p = wa * wb;
        return (op == 2'd0) ? p[3:0] : p[7:4];
    endfunction

    // One 32-bit operation; optionally pokes a start while busy (R9).
    task automatic run32(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input bit intrude, input string tag);
        logic [31:0] exp;
        logic [31:0] held;
        int n;
        exp = ref32(op, a, b);
        @(negedge clk);
        op32 = op; a32 = a; b32 = b; st32 = 1'b1;
        @(negedge clk);
        st32 = 1'b0;
        check(busy32 === 1'b1, "R2 busy after start", 64'(busy32), 64'd1);
        n = 0;
        while (!dn32 && n < 200) begin
            if (intrude && n == 5) begin
                st32 = 1'b1; a32 = ~a; b32 = b ^ 32'h1234_5678; op32 = op + 2'd1;
            end else begin
                st32 = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        st32 = 1'b0;
        check(n == 33 && dn32 === 1'b1, intrude ? "R9 timing" : "R3 latency",
              64'(n), 64'd33);
        check(busy32 === 1'b0, "R3 busy low with done", 64'(busy32), 64'd0);
        check(res32 === exp, intrude ? "R9 result" : tag, {32'h0, res32}, {32'h0, exp});
        held = res32;
        a32 = $urandom; b32 = $urandom; op32 = 2'(op + 2'd2);
        @(negedge clk);
        check(dn32 === 1'b0, "R3 done one cycle", 64'(dn32), 64'd0);
        check(busy32 === 1'b0, intrude ? "R9 no second run" : "R3 idle after done",
              64'(busy32), 64'd0);
        @(negedge clk);
        @(negedge clk);
        check(res32 === held, "R8 result held", {32'h0, res32}, {32'h0, held});
    endtask

    // One 4-bit operation for the sweep.
    task automatic run4(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
        logic [3:0] exp;
        int n;
        exp = ref4(op, a, b);
        @(negedge clk);
        op4 = op; a4 = a; b4 = b; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        n = 0;
        while (!dn4 && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == 5, "R3 latency small", 64'(n), 64'd5);
        check(res4 === exp, op_req(op), 64'(res4), 64'(exp));
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errs++;
            vecs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy32 === 1'b0, "R1 busy", 64'(busy32), 64'd0);
        check(dn32 === 1'b0, "R1 done", 64'(dn32), 64'd0);
        check(res32 === 32'h0, "R1 result", {32'h0, res32}, 64'd0);

        // R10 corner operands under every code
        for (int op = 0; op < 4; op++) begin
            r = $urandom;
            run32(2'(op), 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R10 min*neg1");
            run32(2'(op), 32'h0, 32'h0, 1'b0, "R10 zero*zero");
            run32(2'(op), r | 32'h8000_0000, 32'h0, 1'b0, "R10 neg*zero");
            run32(2'(op), r & 32'h7FFF_FFFF, 32'h0, 1'b0, "R10 pos*zero");
            run32(2'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R10 ones*ones");
            run32(2'(op), 32'h8000_0000, 32'h8000_0000, 1'b0, "R10 min*min");
            run32(2'(op), 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R10 max*min");
        end

        // R4 R5 R6 R7 random operands
        for (int i = 0; i < 160; i++) begin
            logic [1:0] op;
            op = 2'(i % 4);
            run32(op, $urandom, $urandom, 1'b0, op_req(op));
        end

        // R9 start while busy
        run32(2'd1, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1, "R9");
        run32(2'd0, 32'h8765_4321, 32'hFFFF_0001, 1'b1, "R9");

        // Exhaustive 4-bit sweep, all codes (R4 R5 R6 R7)
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(2'(op), 4'(a), 4'(b));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule